// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Priority Encoding

This block gathers interrupt sources into two 8-bit local groups and one 8-bit group of mappable sources. Each local group has a status input and a mask register. The mappable group has one shared status vector and two mask registers of its own. Each of those two masks feeds the masked mappable sources into one reserved cascade bit of its own local group: bit 2 of local group 0 and bit 3 of local group 1. For each local group the block gives a request flag and a 5-bit identifier of the highest pending source, after any cascade has been resolved.

A second stage picks one winner among the CPU timer line, the two local groups, the bus-error line and the two external timer lines. Software programs the four masks through a small synchronous register port and can read them back.

Top module: `irqc_top`

## Requirements
- R1: A local group considers only the bits that are set in both its status input and its effective mask. A source whose mask bit is clear never produces a request.
- R2: Within an 8-bit vector the highest set bit wins. Bit 7 has the highest priority and bit 0 the lowest. The identifier is {group code, bit index}. Group code 00 is local group 0 and code 01 is local group 1.
- R3: A group with no pending source drives its valid flag to 0 and its identifier to 0.
- R4: In local group 0, bit 2 is the cascade bit. It is pending when the shared mappable status ANDed with mappable mask 0 is non-zero. While it is pending, it overrides every other group-0 bit. The identifier is then {2'b10, index of the highest set bit of that AND}.
- R5: In local group 1, bit 3 is the cascade bit and it uses mappable mask 1. The identifier is then {2'b11, index}.
- R6: The cascade bit of each local mask equals the OR of the bits of the matching mappable mask. Software writes to that mask bit have no effect, and neither does the local status input at that bit position. Readback shows the effective value.
- R7: The winner order is: CPU timer (code 0), local group 0 (code 1), local group 1 (code 2), bus error (code 3), then either external timer (code 4).
- R8: Only one winner is reported at a time. A lower request that stays pending is reported in the cycle after all higher requests drop. With no request, the winner valid flag is 0 and the code is 0.
- R9: Reset clears all four mask registers and all outputs.
- R10: A write with the write enable high stores the data at the selected address: 0 is local mask 0, 1 is local mask 1, 2 is mappable mask 0 and 3 is mappable mask 1. With the write enable low, nothing is stored. The read data shows the selected register without delay.
- R11: The group and winner outputs are registered. They reflect a status change one clock edge after it is applied, and a mask write two edges after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Mask register write enable |
| reg_addr | input | 2 | Mask register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected mask |
| loc0_stat | input | 8 | Local group 0 status |
| loc1_stat | input | 8 | Local group 1 status |
| map_stat | input | 8 | Shared mappable status |
| cpu_tmr | input | 1 | CPU timer request |
| bus_err | input | 1 | Bus error request |
| ext_tmr0 | input | 1 | External timer 0 request |
| ext_tmr1 | input | 1 | External timer 1 request |
| g0_valid | output | 1 | Local group 0 request |
| g0_id | output | 5 | Local group 0 source identifier |
| g1_valid | output | 1 | Local group 1 request |
| g1_id | output | 5 | Local group 1 source identifier |
| win_valid | output | 1 | A winner is present |
| win_src | output | 3 | Winner code |

## Verification
A status or timer change is applied at a falling edge, and the results are read at the next falling edge, after exactly one rising edge. A mask write takes effect at the edge that ends the write cycle, so all table vectors finish their writes before the status is applied. One directed case also reads the outputs before that edge to confirm the old value still holds. Readback is checked in the same cycle as the address, and a check follows each write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int GRP_W   = 8;
  localparam int IDX_W   = $clog2(GRP_W);
  localparam int ID_W    = IDX_W + 2;
  localparam int NUM_ARB = 5;
  localparam int SRC_W   = 3;

  typedef enum logic [1:0] {
    ADR_LOC0 = 2'd0,
    ADR_LOC1 = 2'd1,
    ADR_MAP0 = 2'd2,
    ADR_MAP1 = 2'd3
  } mask_addr_e;

  typedef enum logic [SRC_W-1:0] {
    WIN_CPU_TMR = 3'd0,
    WIN_LOC0    = 3'd1,
    WIN_LOC1    = 3'd2,
    WIN_BUS_ERR = 3'd3,
    WIN_EXT_TMR = 3'd4
  } win_code_e;
endpackage

// File: rtl/irqc_prio8.sv
module irqc_prio8 #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = i[IW-1:0];
    end
  end
endmodule

// File: rtl/irqc_masks.sv
module irqc_masks #(
  parameter int GW    = 8,
  parameter int CASC0 = 2,
  parameter int CASC1 = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [GW-1:0] wdata,
  output logic [GW-1:0] rdata,
  output logic [GW-1:0] loc0_eff,
  output logic [GW-1:0] loc1_eff,
  output logic [GW-1:0] map0,
  output logic [GW-1:0] map1
);
  import irqc_pkg::*;
  localparam int NREG = 4;

  logic [GW-1:0] mreg_q [NREG];
  logic [GW-1:0] mreg_d [NREG];

  always_comb begin
    for (int i = 0; i < NREG; i++) mreg_d[i] = mreg_q[i];
    if (we) mreg_d[addr] = wdata;
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mreg_q[g] <= '0;
        else if (we) mreg_q[g] <= mreg_d[g];
      end
    end
  endgenerate

  always_comb begin
    map0            = mreg_q[ADR_MAP0];
    map1            = mreg_q[ADR_MAP1];
    loc0_eff        = mreg_q[ADR_LOC0];
    loc0_eff[CASC0] = |mreg_q[ADR_MAP0];
    loc1_eff        = mreg_q[ADR_LOC1];
    loc1_eff[CASC1] = |mreg_q[ADR_MAP1];
    case (mask_addr_e'(addr))
      ADR_LOC0: rdata = loc0_eff;
      ADR_LOC1: rdata = loc1_eff;
      ADR_MAP0: rdata = map0;
      default:  rdata = map1;
    endcase
  end

  AST_WR_MAP0: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd2) |=> (map0 == $past(wdata))); // R10
  AST_HOLD_MAP1: assert property (@(posedge clk) disable iff (!rst_n)
    (!we) |=> $stable(map1)); // R10
  AST_CASC_FOLLOW0: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 2'd2 && wdata == '0) |=> !loc0_eff[CASC0]); // R6
endmodule

// File: rtl/irqc_group.sv
module irqc_group #(
  parameter int         GW   = 8,
  parameter int         CASC = 2,
  parameter logic [1:0] LCODE = 2'b00,
  parameter logic [1:0] MCODE = 2'b10,
  localparam int        IW   = $clog2(GW),
  localparam int        IDW  = IW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [GW-1:0]  stat,
  input  logic [GW-1:0]  lmask,
  input  logic [GW-1:0]  map_stat,
  input  logic [GW-1:0]  mmask,
  output logic           req_nxt,
  output logic           valid,
  output logic [IDW-1:0] id
);
  logic [GW-1:0]  map_hit;
  logic [GW-1:0]  loc_act;
  logic           map_any, loc_any;
  logic [IW-1:0]  map_idx, loc_idx;
  logic [IDW-1:0] id_d;

  always_comb begin
    map_hit       = map_stat & mmask;
    loc_act       = stat & lmask;
    loc_act[CASC] = lmask[CASC] & (|map_hit);
  end

  irqc_prio8 #(.W(GW)) u_map (.vec(map_hit), .hit(map_any), .idx(map_idx));
  irqc_prio8 #(.W(GW)) u_loc (.vec(loc_act), .hit(loc_any), .idx(loc_idx));

  always_comb begin
    req_nxt = loc_any;
    id_d    = '0;
    if (loc_act[CASC] && map_any) id_d = {MCODE, map_idx};
    else if (loc_any)             id_d = {LCODE, loc_idx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      id    <= '0;
    end else begin
      valid <= req_nxt;
      id    <= id_d;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (id == '0)); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & lmask) == '0 && map_hit == '0) |=> !valid); // R1
  AST_CASC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (map_hit != '0) |=> (valid && id[IDW-1:IDW-2] == MCODE)); // R4
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int N  = 5,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          win_valid,
  output logic [SW-1:0] win_src
);
  logic          v_d;
  logic [SW-1:0] s_d;

  always_comb begin
    v_d = |req;
    s_d = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) s_d = i[SW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_src   <= '0;
    end else begin
      win_valid <= v_d;
      win_src   <= s_d;
    end
  end

  AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req[0] |=> (win_valid && win_src == '0)); // R7
  AST_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (!win_valid && win_src == '0)); // R8
  AST_LOWER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req[1] && req[2]) |=> (win_src != SW'(2))); // R8
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int GW    = irqc_pkg::GRP_W,
  parameter int CASC0 = 2,
  parameter int CASC1 = 3,
  localparam int IDW  = $clog2(GW) + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [GW-1:0]  reg_wdata,
  output logic [GW-1:0]  reg_rdata,
  input  logic [GW-1:0]  loc0_stat,
  input  logic [GW-1:0]  loc1_stat,
  input  logic [GW-1:0]  map_stat,
  input  logic           cpu_tmr,
  input  logic           bus_err,
  input  logic           ext_tmr0,
  input  logic           ext_tmr1,
  output logic           g0_valid,
  output logic [IDW-1:0] g0_id,
  output logic           g1_valid,
  output logic [IDW-1:0] g1_id,
  output logic           win_valid,
  output logic [2:0]     win_src
);
  import irqc_pkg::*;

  logic [GW-1:0] loc0_eff, loc1_eff, map0, map1;
  logic          g0_req, g1_req;
  logic [NUM_ARB-1:0] arb_req;

  irqc_masks #(.GW(GW), .CASC0(CASC0), .CASC1(CASC1)) u_masks (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .loc0_eff(loc0_eff), .loc1_eff(loc1_eff), .map0(map0), .map1(map1)
  );

  irqc_group #(.GW(GW), .CASC(CASC0), .LCODE(2'b00), .MCODE(2'b10)) u_grp0 (
    .clk(clk), .rst_n(rst_n), .stat(loc0_stat), .lmask(loc0_eff),
    .map_stat(map_stat), .mmask(map0),
    .req_nxt(g0_req), .valid(g0_valid), .id(g0_id)
  );

  irqc_group #(.GW(GW), .CASC(CASC1), .LCODE(2'b01), .MCODE(2'b11)) u_grp1 (
    .clk(clk), .rst_n(rst_n), .stat(loc1_stat), .lmask(loc1_eff),
    .map_stat(map_stat), .mmask(map1),
    .req_nxt(g1_req), .valid(g1_valid), .id(g1_id)
  );

  always_comb begin
    arb_req              = '0;
    arb_req[WIN_CPU_TMR] = cpu_tmr;
    arb_req[WIN_LOC0]    = g0_req;
    arb_req[WIN_LOC1]    = g1_req;
    arb_req[WIN_BUS_ERR] = bus_err;
    arb_req[WIN_EXT_TMR] = ext_tmr0 | ext_tmr1;
  end

  irqc_arb #(.N(NUM_ARB)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(arb_req),
    .win_valid(win_valid), .win_src(win_src)
  );

  AST_G0_OVER_G1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_tmr && g0_req) |=> (win_src == 3'd1)); // R7
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic       clk, rst_n;
  logic       reg_we;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] loc0_stat, loc1_stat, map_stat;
  logic       cpu_tmr, bus_err, ext_tmr0, ext_tmr1;
  logic       g0_valid, g1_valid, win_valid;
  logic [4:0] g0_id, g1_id;
  logic [2:0] win_src;

  int n_cmp = 0;
  int n_bad = 0;

  irqc_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .loc0_stat(loc0_stat), .loc1_stat(loc1_stat), .map_stat(map_stat),
    .cpu_tmr(cpu_tmr), .bus_err(bus_err), .ext_tmr0(ext_tmr0), .ext_tmr1(ext_tmr1),
    .g0_valid(g0_valid), .g0_id(g0_id), .g1_valid(g1_valid), .g1_id(g1_id),
    .win_valid(win_valid), .win_src(win_src)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // t field order: {cpu_tmr, bus_err, ext_tmr1, ext_tmr0}
  typedef struct packed {
    logic [7:0] lm0, lm1, mm0, mm1, s0, s1, ms;
    logic [3:0] t;
    logic       g0v; logic [4:0] g0i;
    logic       g1v; logic [4:0] g1i;
    logic       wv;  logic [2:0] ws;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{8'h00,8'h00,8'h00,8'h00,8'hFF,8'hFF,8'hFF,4'h0, 1'b0,5'd0,  1'b0,5'd0,  1'b0,3'd0},
    '{8'hFF,8'h00,8'h00,8'h00,8'h81,8'hFF,8'hFF,4'h0, 1'b1,5'd7,  1'b0,5'd0,  1'b1,3'd1},
    '{8'h0F,8'hF0,8'h00,8'h00,8'h0A,8'h30,8'h00,4'h0, 1'b1,5'd3,  1'b1,5'd13, 1'b1,3'd1},
    '{8'hFF,8'h00,8'h06,8'h00,8'h80,8'h00,8'h04,4'h0, 1'b1,5'd18, 1'b0,5'd0,  1'b1,3'd1},
    '{8'hFF,8'h01,8'h06,8'h80,8'h80,8'h01,8'h84,4'h8, 1'b1,5'd18, 1'b1,5'd31, 1'b1,3'd0},
    '{8'hFF,8'h08,8'h00,8'h00,8'h04,8'h08,8'hFF,4'h4, 1'b0,5'd0,  1'b0,5'd0,  1'b1,3'd3},
    '{8'h00,8'h01,8'h00,8'h00,8'hFF,8'h01,8'h00,4'h5, 1'b0,5'd0,  1'b1,5'd8,  1'b1,3'd2},
    '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,4'h2, 1'b0,5'd0,  1'b0,5'd0,  1'b1,3'd4},
    '{8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,4'h6, 1'b0,5'd0,  1'b0,5'd0,  1'b1,3'd3},
    '{8'hFF,8'h00,8'h00,8'h00,8'h05,8'h00,8'hFF,4'h0, 1'b1,5'd0,  1'b0,5'd0,  1'b1,3'd1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    loc0_stat = '0; loc1_stat = '0; map_stat = '0;
    cpu_tmr = 0; bus_err = 0; ext_tmr0 = 0; ext_tmr1 = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 g0_valid", {7'd0, g0_valid}, 8'd0);
    chk("R9 win_valid", {7'd0, win_valid}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) rd_chk("R9 mask clear", 2'(a), 8'h00);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R11
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VT[i].lm0);
      wr(2'd1, VT[i].lm1);
      wr(2'd2, VT[i].mm0);
      wr(2'd3, VT[i].mm1);
      loc0_stat = VT[i].s0; loc1_stat = VT[i].s1; map_stat = VT[i].ms;
      {cpu_tmr, bus_err, ext_tmr1, ext_tmr0} = VT[i].t;
      @(negedge clk);
      chk($sformatf("R2 vec%0d g0_valid", i), {7'd0, g0_valid}, {7'd0, VT[i].g0v});
      chk($sformatf("R4 vec%0d g0_id", i),    {3'd0, g0_id},    {3'd0, VT[i].g0i});
      chk($sformatf("R5 vec%0d g1_valid", i), {7'd0, g1_valid}, {7'd0, VT[i].g1v});
      chk($sformatf("R1 vec%0d g1_id", i),    {3'd0, g1_id},    {3'd0, VT[i].g1i});
      chk($sformatf("R7 vec%0d win_valid", i),{7'd0, win_valid},{7'd0, VT[i].wv});
      chk($sformatf("R7 vec%0d win_src", i),  {5'd0, win_src},  {5'd0, VT[i].ws});
    end
    loc0_stat = '0; loc1_stat = '0; map_stat = '0;
    {cpu_tmr, bus_err, ext_tmr1, ext_tmr0} = 4'h0;

    // R6: cascade mask bit follows mappable mask, writes to it ignored
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    rd_chk("R6 casc bit off", 2'd0, 8'hFB);
    wr(2'd2, 8'h10);
    rd_chk("R6 casc bit on", 2'd0, 8'hFF);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h08);
    rd_chk("R6 casc1 write ignored", 2'd1, 8'h00);

    // R10: write enable low stores nothing
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd2; reg_wdata = 8'h5A;
    @(negedge clk);
    rd_chk("R10 we low", 2'd2, 8'h10);
    wr(2'd3, 8'hC3);
    rd_chk("R10 write map1", 2'd3, 8'hC3);
    wr(2'd3, 8'h00);

    // R11: result not visible before the edge, visible after it
    wr(2'd2, 8'h00);
    @(negedge clk);
    loc0_stat = 8'h40;
    #1;
    chk("R11 before edge", {7'd0, g0_valid}, 8'd0);
    @(negedge clk);
    chk("R11 after edge valid", {7'd0, g0_valid}, 8'd1);
    chk("R11 after edge id", {3'd0, g0_id}, 8'd6);

    // R8: lower request taken once higher drops
    cpu_tmr = 1'b1;
    @(negedge clk);
    chk("R8 cpu wins", {5'd0, win_src}, 8'd0);
    cpu_tmr = 1'b0;
    @(negedge clk);
    chk("R8 local0 next", {5'd0, win_src}, 8'd1);
    loc0_stat = '0;
    @(negedge clk);
    chk("R8 idle valid", {7'd0, win_valid}, 8'd0);
    chk("R8 idle src", {5'd0, win_src}, 8'd0);

    // R9: reset mid-run clears masks
    wr(2'd1, 8'hAA);
    rst_n = 1'b0;
    #1;
    rd_chk("R9 mid reset", 2'd1, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R9 after reset", 2'd0, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule